// File: doc/BRIEF.md
# TDM Serial Stream Port

This block terminates one time-division-multiplexed serial link: a single input stream and a single output stream, each carrying a frame of 32 byte-wide channels at 2048 kb/s. Every channel therefore runs at 64 kb/s, and frames repeat every 125 µs (8 kHz). The block runs from a clock at twice the bit rate (4096 kHz), so one bit cell spans two clock periods. An active-low frame pulse, one clock period wide, marks where each frame begins. From these two signals the block finds the frame boundary and keeps count of the bit cell, the bit within the channel, and the channel.

The block exchanges one channel with the parallel side, chosen by a channel-select input. Incoming bits of that channel are gathered into a receive byte, and a one-cycle valid strobe marks each new byte. A transmit byte supplied in parallel is captured just before the chosen channel starts and is shifted out most significant bit first. In every other channel the output rests at its idle high level. Input bits are taken at the three-quarter point of each cell, on the falling clock edge inside the cell's second half. The output changes only on the rising edge that opens a cell.

Top module: `tdm_stream_port`

## Requirements
- R1: While reset is asserted, `dout` is 1, `rx_valid` is 0 and `rx_byte` is 0.
- R2: Until the first frame pulse has been seen after reset, `dout` stays 1 and `rx_valid` stays 0.
- R3: When `fp_n` is low at a falling clock edge, the following rising edge opens bit cell 0 of channel 0. Each cell lasts two clock periods, channel c holds cells 8c to 8c+7, and a frame has 256 cells (512 clocks).
- R4: Within the selected channel, `dout` carries the latched transmit byte most significant bit first, one bit per cell. It changes only on the rising edge that opens a cell.
- R5: In every channel other than the selected one, `dout` is 1.
- R6: `tx_byte` is captured on the rising edge that opens the selected channel's first cell. Changes to `tx_byte` later in that channel have no effect on `dout`.
- R7: `din` is taken on the falling edge in the middle of each cell's second clock period. `rx_byte` holds the selected channel's 8 bits, with the first received bit as bit 7.
- R8: `rx_valid` is high for exactly one clock period. That period starts at the rising edge that closes the selected channel's eighth cell (16 clocks after the channel opens), and `rx_byte` is valid during it.
- R9: `sel_ch` is captured when a frame starts and holds for the whole frame. Changes to `sel_ch` at any other time take effect only at the next frame start.
- R10: A frame pulse arriving before 256 cells have been counted realigns the counters to a new frame at once.
- R11: With no frame pulse, the count wraps after 512 clocks and the next frame proceeds with the same selected channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse |
| din | input | 1 | Serial input stream |
| sel_ch | input | 5 | Channel exchanged with the parallel side |
| tx_byte | input | 8 | Byte to send in the selected channel |
| dout | output | 1 | Serial output stream |
| rx_byte | output | 8 | Last byte received in the selected channel |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |

## Verification
A frame pulse seen low at a falling edge sets the count to zero one rising edge later. An output bit appears during the clock period that follows the rising edge opening its cell. The receive strobe and byte appear during the clock period after the rising edge that takes in the eighth bit. The bench keeps a cycle-accurate model of the cell position, the selected channel, the captured transmit byte and a shift register of received bits. It compares `dout`, `rx_valid` and `rx_byte` with that model a quarter period after every rising edge, and changes its inputs only after sampling. Random data, channel selects and transmit bytes change every cycle, so the timing of every capture is checked.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  localparam int unsigned DEF_CHANNELS  = 32;
  localparam int unsigned DEF_SLOT_BITS = 8;

  typedef enum logic {
    LOCK_HUNT = 1'b0,
    LOCK_HELD = 1'b1
  } lock_e;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_port_pkg::*;
#(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned LAST  = 511
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_n,
  output logic             frame_go,
  output lock_e            lock_q,
  output lock_e            lock_nx,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx
);
  logic fp_s;

  // frame pulse taken on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fp_s <= 1'b1;
    else        fp_s <= fp_n;
  end

  assign frame_go = ~fp_s;

  always_comb begin
    lock_nx = lock_q;
    if (frame_go) begin
      cnt_nx  = '0;
      lock_nx = LOCK_HELD;
    end else if (cnt_q == CNT_W'(LAST)) begin
      cnt_nx = '0;
    end else begin
      cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= LOCK_HUNT;
    end else begin
      cnt_q  <= cnt_nx;
      lock_q <= lock_nx;
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din,
  input  logic                 shift_en,
  input  logic                 catch_en,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  logic                 din_s;
  logic [SLOT_BITS-1:0] sh_q, sh_nx, byte_q, byte_nx;
  logic                 vld_q, vld_nx;

  // three-quarter point of the cell is a falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) din_s <= 1'b1;
    else        din_s <= din;
  end

  always_comb begin
    sh_nx   = shift_en ? {sh_q[SLOT_BITS-2:0], din_s} : sh_q;
    byte_nx = catch_en ? sh_nx : byte_q;
    vld_nx  = catch_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_nx;
      byte_q <= byte_nx;
      vld_q  <= vld_nx;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_valid = vld_q;
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_port_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned BIT_W     = 3,
  parameter int unsigned CH_W      = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lock_e                lock_nx,
  input  logic                 ph_nx,
  input  logic [BIT_W-1:0]     bit_nx,
  input  logic [CH_W-1:0]      ch_nx,
  input  logic [CH_W-1:0]      sel_eff,
  input  logic [SLOT_BITS-1:0] tx_byte,
  output logic                 dout
);
  logic [SLOT_BITS-1:0] hold_q, hold_nx;
  logic                 dout_q, dout_nx;
  logic [BIT_W-1:0]     idx;

  assign idx = BIT_W'(SLOT_BITS - 1) - bit_nx;

  always_comb begin
    hold_nx = hold_q;
    dout_nx = dout_q;
    if (!ph_nx) begin
      if (lock_nx == LOCK_HELD && ch_nx == sel_eff) begin
        if (bit_nx == '0) begin
          hold_nx = tx_byte;
          dout_nx = tx_byte[SLOT_BITS-1];
        end else begin
          dout_nx = hold_q[idx];
        end
      end else begin
        dout_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '1;
      dout_q <= 1'b1;
    end else begin
      hold_q <= hold_nx;
      dout_q <= dout_nx;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/tdm_stream_port.sv
module tdm_stream_port
  import tdm_port_pkg::*;
#(
  parameter int unsigned N_CH      = DEF_CHANNELS,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  localparam int unsigned CH_W     = $clog2(N_CH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fp_n,
  input  logic                 din,
  input  logic [CH_W-1:0]      sel_ch,
  input  logic [SLOT_BITS-1:0] tx_byte,
  output logic                 dout,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  localparam int unsigned BIT_W = $clog2(SLOT_BITS);
  localparam int unsigned CNT_W = CH_W + BIT_W + 1;
  localparam int unsigned LAST  = N_CH * SLOT_BITS * 2 - 1;

  logic [1:0]       rst_pipe;
  logic             rst_i_n;
  logic             frame_go;
  lock_e            lock_q, lock_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CH_W-1:0]  sel_q, sel_nx;
  logic             ph_q, ph_nx;
  logic [BIT_W-1:0] bit_q, bit_nx;
  logic [CH_W-1:0]  ch_q, ch_nx;
  logic             shift_en, catch_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  tdm_frame_timer #(.CNT_W(CNT_W), .LAST(LAST)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .fp_n     (fp_n),
    .frame_go (frame_go),
    .lock_q   (lock_q),
    .lock_nx  (lock_nx),
    .cnt_q    (cnt_q),
    .cnt_nx   (cnt_nx)
  );

  assign ph_q  = cnt_q[0];
  assign bit_q = cnt_q[BIT_W:1];
  assign ch_q  = cnt_q[CNT_W-1:BIT_W+1];
  assign ph_nx  = cnt_nx[0];
  assign bit_nx = cnt_nx[BIT_W:1];
  assign ch_nx  = cnt_nx[CNT_W-1:BIT_W+1];

  // channel select held for a whole frame
  always_comb sel_nx = frame_go ? sel_ch : sel_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) sel_q <= '0;
    else          sel_q <= sel_nx;
  end

  assign shift_en = (lock_q == LOCK_HELD) && ph_q;
  assign catch_en = shift_en && (bit_q == BIT_W'(SLOT_BITS - 1)) && (ch_q == sel_q);

  tdm_rx_deser #(.SLOT_BITS(SLOT_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .din      (din),
    .shift_en (shift_en),
    .catch_en (catch_en),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid)
  );

  tdm_tx_ser #(.SLOT_BITS(SLOT_BITS), .BIT_W(BIT_W), .CH_W(CH_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .lock_nx (lock_nx),
    .ph_nx   (ph_nx),
    .bit_nx  (bit_nx),
    .ch_nx   (ch_nx),
    .sel_eff (sel_nx),
    .tx_byte (tx_byte),
    .dout    (dout)
  );
endmodule

// File: rtl/tdm_stream_port_chk.sv
module tdm_stream_port_chk
  import tdm_port_pkg::*;
#(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned CH_W  = 5,
  parameter int unsigned LAST  = 511
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_go,
  input lock_e            lock_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CH_W-1:0]  ch_q,
  input logic [CH_W-1:0]  sel_q,
  input logic             dout,
  input logic             rx_valid
);
  // R2
  hunt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q == LOCK_HUNT) |-> (dout && !rx_valid));

  // R4
  cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[0] |-> $stable(dout));

  // R5
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q == LOCK_HELD && ch_q != sel_q) |-> dout);

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> (cnt_q == '0));

  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_go && cnt_q == CNT_W'(LAST)) |=> (cnt_q == '0));
endmodule

bind tdm_stream_port tdm_stream_port_chk #(.CNT_W(CNT_W), .CH_W(CH_W), .LAST(LAST)) u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .frame_go (frame_go),
  .lock_q   (lock_q),
  .cnt_q    (cnt_q),
  .ch_q     (ch_q),
  .sel_q    (sel_q),
  .dout     (dout),
  .rx_valid (rx_valid)
);

// File: tb/tb_tdm_stream_port.sv
`timescale 1ns/1ps
module tb_tdm_stream_port;
  localparam int CLK_PERIOD = 244;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int FRAME_CLKS = 512;

  logic       clk, rst_n, fp_n, din, dout, rx_valid;
  logic [4:0] sel_ch;
  logic [7:0] tx_byte, rx_byte;

  int checks = 0;
  int errors = 0;

  // bench model state
  int         pos    = 0;
  bit         locked = 0;
  logic [4:0] sel_m  = '0;
  logic [7:0] tx_m   = '1;
  logic [7:0] rx_sh  = '0;
  logic [7:0] exp_rx = '0;
  bit         exp_v  = 0;
  string      ctx    = "R3";

  tdm_stream_port dut (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .din(din), .sel_ch(sel_ch),
    .tx_byte(tx_byte), .dout(dout), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic logic exp_dout(int p, bit lk, logic [4:0] s, logic [7:0] t);
    if (!lk || (p >> 4) != s) return 1'b1;
    return t[7 - ((p >> 1) & 7)];
  endfunction

  function automatic string dout_req(int p, bit lk, logic [4:0] s);
    if (!lk) return "R2";
    if ((p >> 4) != s) return "R5";
    return "R4/R6";
  endfunction

  // one clock period: sample, drive, advance model
  task automatic step(input bit fp_low, input int sel_force);
    bit v_nx;
    @(posedge clk); #(QTR);
    chk({dout_req(pos, locked, sel_m), " ", ctx, " dout"}, {7'd0, dout},
        {7'd0, exp_dout(pos, locked, sel_m, tx_m)});
    chk({"R8 ", ctx, " rx_valid"}, {7'd0, rx_valid}, {7'd0, exp_v});
    if (exp_v) chk({"R7 ", ctx, " rx_byte"}, rx_byte, exp_rx);
    fp_n    = ~fp_low;
    sel_ch  = (sel_force >= 0) ? 5'(sel_force) : 5'($urandom);
    tx_byte = 8'($urandom);
    if (!locked || (pos % 2) == 0) din = 1'($urandom);
    v_nx = 0;
    if (locked && (pos % 2) == 1) begin
      rx_sh = {rx_sh[6:0], din};
      if (((pos >> 1) & 7) == 7 && (pos >> 4) == sel_m) begin
        v_nx   = 1;
        exp_rx = rx_sh;
      end
    end
    if (fp_low) begin
      pos = 0; locked = 1; sel_m = sel_ch;
    end else begin
      pos = (pos + 1) % FRAME_CLKS;
    end
    if (locked && (pos % 16) == 0 && (pos >> 4) == sel_m) tx_m = tx_byte;
    exp_v = v_nx;
  endtask

  task automatic run_frame(input int sel_force, input int len);
    step(1'b1, sel_force);
    for (int i = 1; i < len; i++) step(1'b0, -1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_7d11));
    rst_n = 1'b0; fp_n = 1'b1; din = 1'b1; sel_ch = '0; tx_byte = '0;
    repeat (3) @(posedge clk);
    #(QTR);
    // R1: reset values
    chk("R1 dout", {7'd0, dout}, 8'd1);
    chk("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
    chk("R1 rx_byte", rx_byte, 8'd0);
    rst_n = 1'b1;
    // R2: no frame pulse yet
    ctx = "R2";
    for (int i = 0; i < 300; i++) step(1'b0, -1);
    // R3 / R9: aligned frames, selects random every cycle, edge channels directed
    ctx = "R3";
    run_frame(0, FRAME_CLKS);
    run_frame(31, FRAME_CLKS);
    ctx = "R9";
    for (int f = 0; f < 4; f++) run_frame(-1, FRAME_CLKS);
    // R10: early frame pulses
    ctx = "R10";
    run_frame(5, 40 + int'($urandom % 400));
    run_frame(-1, 17);
    run_frame(31, 301);
    run_frame(2, FRAME_CLKS);
    // R11: missing frame pulses, free-running wrap
    ctx = "R11";
    run_frame(-1, FRAME_CLKS * 3);
    ctx = "R3";
    run_frame(-1, FRAME_CLKS);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule